// File: doc/BRIEF.md
# SPI Port with Host-Request Word Pacing

The block is a serial host port that runs as either an SPI slave or an SPI master. The `cfg_master` bit selects the role. An active-low host-request line paces every word in both roles. As a slave the port drives host-request low once a transmit word has been loaded, which tells the remote master the port is ready. The line returns high when the first SCK rising edge of that word arrives. As a master the port samples the line as an input and starts a loaded word only when the remote slave holds it low. After each word it waits for the line to be low again.

Words are `WORD_W` bits wide and travel MSB first. Data is sampled on the rising SCK edge and changed on the falling edge. SCK idles low. In master mode SCK comes from the system clock: each half period lasts `HALF_DIV` system clocks. In slave mode the slave-select, SCK and host-request pins pass through a two-flop synchroniser before use. A sticky bus-error flag records slave select being asserted while the port is the master. While the flag is set, no new master word can start. A pulse on `err_clr` clears the flag.

The controller has six states:
- `ST_IDLE`: no word is loaded.
- `ST_SL_READY`: a slave word is loaded and host-request is low.
- `ST_SL_SHIFT`: a slave word is being exchanged.
- `ST_MS_WAIT`: a master word is loaded and the port waits for host-request.
- `ST_MS_SHIFT`: the master is generating SCK.
- `ST_DONE`: the received word is published.

Transitions:
- From IDLE, `tx_load` leads to SL_READY or MS_WAIT, depending on the mode.
- SL_READY moves to SL_SHIFT on the first qualified SCK rise.
- SL_SHIFT moves to DONE on the last rise of the word.
- MS_WAIT moves to MS_SHIFT when host-request is low (or handling is disabled) and no bus error is pending.
- MS_SHIFT moves to DONE on the falling edge after the last rise.
- DONE always returns to IDLE.

Top module: `spi_hreq_port`

## Requirements
- R1: In slave mode, with `ss_n` low, a loaded word appears on `miso_o` MSB first; each bit is valid at the SCK rising edge and changes after the falling edge. The `WORD_W` bits sampled from `mosi_i` on rising edges appear on `rx_word`, MSB first.
- R2: In slave mode with handling enabled, `hreq_o` goes low (ready) once a word is loaded in idle. It returns high after the first SCK rising edge of that word.
- R3: While `ss_n` is high, a slave ignores every SCK edge: no bit is shifted, no word completes and host-request stays low. `miso_oe` stays low during that time.
- R4: In master mode, a loaded word starts only when the synchronised `hreq_i` is low, or at once when `cfg_hreq_en` is 00. The master then produces exactly `WORD_W` SCK pulses, each half period `HALF_DIV` clocks long, and SCK ends the word low. It sends the word on `mosi_o` MSB first and captures `miso_i` on rising edges.
- R5: After a master word ends, a newly loaded word does not start while `hreq_i` stays high.
- R6: `hreq_oe` is low during reset, in master mode and when `cfg_hreq_en` is 00. It is high in slave mode for any nonzero `cfg_hreq_en`.
- R7: In master mode, `ss_n` low sets `bus_err`. The flag stays set until an `err_clr` pulse arrives in a cycle where no new error is detected; if setting and clearing fall in the same cycle, setting wins.
- R8: While `bus_err` is set, a waiting master word does not start, even with `hreq_i` low.
- R9: A `tx_load` pulse arriving while a word is pending or in flight is ignored; the earlier word is the one sent.
- R10: `rx_valid` is a single-cycle pulse after each completed word. `rx_word` changes only with that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master, 0 = slave; change only in idle |
| cfg_hreq_en | input | 2 | Host-request handling: 00 off (pin released), any other value on |
| tx_word | input | WORD_W | Word to transmit |
| tx_load | input | 1 | Load strobe for `tx_word`, taken only in idle |
| rx_word | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` is updated |
| err_clr | input | 1 | Clear pulse for `bus_err` |
| bus_err | output | 1 | Sticky bus-error flag |
| sck_i | input | 1 | SCK from the remote master (slave mode) |
| sck_o | output | 1 | Generated SCK (master mode), idle low |
| mosi_i | input | 1 | Serial data in (slave mode) |
| mosi_o | output | 1 | Serial data out (master mode) |
| miso_i | input | 1 | Serial data in (master mode) |
| miso_o | output | 1 | Serial data out (slave mode) |
| miso_oe | output | 1 | Output enable for `miso_o` |
| ss_n | input | 1 | Active-low slave select |
| hreq_i | input | 1 | Host-request from the remote slave (master mode), active low |
| hreq_o | output | 1 | Host-request to the remote master (slave mode), active low |
| hreq_oe | output | 1 | Output enable for `hreq_o` |

## Verification
Two functions can fall in the same cycle: detection of slave select in master mode, which sets `bus_err`, and an `err_clr` pulse, which clears it. The bench holds `ss_n` low and pulses `err_clr`. It then expects `bus_err` to stay set, and it checks that a waiting word with `hreq_i` low still does not start. Only after `ss_n` is released and `err_clr` is pulsed again does it expect the flag to drop and the word to complete. The two host-request roles are swept over every 8-bit word: each word's exchanged bits are compared with the arithmetic expectation, and the SCK pulse count is compared with `WORD_W`.

// File: rtl/spi_hreq_pkg.sv
package spi_hreq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SL_READY,
        ST_SL_SHIFT,
        ST_MS_WAIT,
        ST_MS_SHIFT,
        ST_DONE
    } port_state_t;
endpackage

// File: rtl/spi_hreq_sync.sv
module spi_hreq_sync #(
    parameter int          W    = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1, s2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= INIT;
            s2 <= INIT;
        end else begin
            s1 <= d;
            s2 <= s1;
        end
    end

    assign q = s2;
endmodule

// File: rtl/spi_hreq_clkgen.sv
module spi_hreq_clkgen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic rise,
    output logic fall
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [DW-1:0] div_cnt;
    logic          tick;

    assign tick = run && (div_cnt == DW'(HALF_DIV - 1));
    assign rise = tick && !sck;
    assign fall = tick && sck;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            sck     <= 1'b0;
        end else if (!run) begin
            div_cnt <= '0;
            sck     <= 1'b0;
        end else if (tick) begin
            div_cnt <= '0;
            sck     <= ~sck;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_hreq_shift.sv
module spi_hreq_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         adv,
    input  logic         samp,
    input  logic         din,
    output logic         tx_bit,
    output logic [W-1:0] rx_val
);
    logic [W-1:0] txr, rxr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txr <= '0;
            rxr <= '0;
        end else begin
            if (load)
                txr <= load_val;
            else if (adv)
                txr <= {txr[W-2:0], 1'b0};
            if (samp)
                rxr <= {rxr[W-2:0], din};
        end
    end

    assign tx_bit = txr[W-1];
    assign rx_val = rxr;
endmodule

// File: rtl/spi_hreq_port.sv
module spi_hreq_port #(
    parameter int WORD_W   = 8,
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic [1:0]        cfg_hreq_en,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_load,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    input  logic              err_clr,
    output logic              bus_err,
    input  logic              sck_i,
    output logic              sck_o,
    input  logic              mosi_i,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_n,
    input  logic              hreq_i,
    output logic              hreq_o,
    output logic              hreq_oe
);
    import spi_hreq_pkg::*;

    localparam int CW = $clog2(WORD_W + 1);

    port_state_t       state, nxt;
    logic [2:0]        pin_q;
    logic              sck_prev;
    logic              s_rise, s_fall, ss_on, hreq_low, hs_on;
    logic              m_run, m_rise, m_fall;
    logic              samp, adv, din, load_word, tx_bit;
    logic [CW-1:0]     bit_cnt;
    logic [WORD_W-1:0] rx_val;

    // bit 0: SCK, bit 1: slave select, bit 2: host-request
    spi_hreq_sync #(.W(3), .INIT(3'b110)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({hreq_i, ss_n, sck_i}),
        .q    (pin_q)
    );

    spi_hreq_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (m_run),
        .sck  (sck_o),
        .rise (m_rise),
        .fall (m_fall)
    );

    spi_hreq_shift #(.W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_word),
        .load_val(tx_word),
        .adv     (adv),
        .samp    (samp),
        .din     (din),
        .tx_bit  (tx_bit),
        .rx_val  (rx_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= pin_q[0];
    end

    assign s_rise    = pin_q[0] & ~sck_prev;
    assign s_fall    = ~pin_q[0] & sck_prev;
    assign ss_on     = ~pin_q[1];
    assign hreq_low  = ~pin_q[2];
    assign hs_on     = |cfg_hreq_en;
    assign din       = cfg_master ? miso_i : mosi_i;
    assign load_word = (state == ST_IDLE) && tx_load;
    assign m_run     = (state == ST_MS_SHIFT);

    always_comb begin
        if (cfg_master) begin
            samp = (state == ST_MS_SHIFT) && m_rise;
            adv  = (state == ST_MS_SHIFT) && m_fall;
        end else begin
            samp = ((state == ST_SL_READY) || (state == ST_SL_SHIFT)) && s_rise && ss_on;
            adv  = (state == ST_SL_SHIFT) && s_fall && ss_on;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (tx_load) nxt = cfg_master ? ST_MS_WAIT : ST_SL_READY;
            ST_SL_READY: if (samp) nxt = ST_SL_SHIFT;
            ST_SL_SHIFT: if (samp && bit_cnt == CW'(WORD_W - 1)) nxt = ST_DONE;
            ST_MS_WAIT:  if (!bus_err && (!hs_on || hreq_low)) nxt = ST_MS_SHIFT;
            ST_MS_SHIFT: if (m_fall && bit_cnt == CW'(WORD_W)) nxt = ST_DONE;
            ST_DONE:     nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 bit_cnt <= '0;
        else if (state == ST_IDLE)  bit_cnt <= '0;
        else if (samp)              bit_cnt <= bit_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      bus_err <= 1'b0;
        else if (cfg_master && ss_on)    bus_err <= 1'b1;
        else if (err_clr)                bus_err <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_word  <= '0;
        end else begin
            rx_valid <= (state == ST_DONE);
            if (state == ST_DONE) rx_word <= rx_val;
        end
    end

    // outputs
    always_comb begin
        hreq_oe = rst_n & ~cfg_master & hs_on;
        hreq_o  = (state != ST_SL_READY);
        miso_oe = rst_n & ~cfg_master & ~ss_n;
        miso_o  = tx_bit;
        mosi_o  = tx_bit;
    end
endmodule

// File: rtl/spi_hreq_port_chk.sv
module spi_hreq_port_chk #(
    parameter int WORD_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_master,
    input logic                      err_clr,
    input logic                      bus_err,
    input logic                      sck_o,
    input logic                      rx_valid,
    input logic [WORD_W-1:0]         rx_word,
    input spi_hreq_pkg::port_state_t state
);
    import spi_hreq_pkg::*;

    // R7
    bus_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !err_clr) |=> bus_err);

    // R10
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R10
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_word));

    // R4
    word_end_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_master) |-> !sck_o);

    // R8
    err_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MS_WAIT && bus_err) |=> (state == ST_MS_WAIT));
endmodule

bind spi_hreq_port spi_hreq_port_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_master(cfg_master),
    .err_clr   (err_clr),
    .bus_err   (bus_err),
    .sck_o     (sck_o),
    .rx_valid  (rx_valid),
    .rx_word   (rx_word),
    .state     (state)
);

// File: tb/spi_hreq_port_bench.sv
module spi_hreq_port_bench;
    localparam int W  = 8;
    localparam int HD = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_master = 1'b0;
    logic [1:0]   cfg_hreq_en = 2'b11;
    logic [W-1:0] tx_word = '0;
    logic         tx_load = 1'b0;
    logic [W-1:0] rx_word;
    logic         rx_valid;
    logic         err_clr = 1'b0;
    logic         bus_err;
    logic         sck_i = 1'b0;
    logic         sck_o;
    logic         mosi_i = 1'b0;
    logic         mosi_o;
    logic         miso_i;
    logic         miso_o;
    logic         miso_oe;
    logic         ss_n = 1'b0;
    logic         hreq_i = 1'b1;
    logic         hreq_o;
    logic         hreq_oe;

    always #4 clk = ~clk;

    spi_hreq_port #(.WORD_W(W), .HALF_DIV(HD)) u_spi_hreq_port (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_hreq_en(cfg_hreq_en),
        .tx_word(tx_word), .tx_load(tx_load), .rx_word(rx_word), .rx_valid(rx_valid),
        .err_clr(err_clr), .bus_err(bus_err), .sck_i(sck_i), .sck_o(sck_o),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .miso_i(miso_i), .miso_o(miso_o),
        .miso_oe(miso_oe), .ss_n(ss_n), .hreq_i(hreq_i), .hreq_o(hreq_o), .hreq_oe(hreq_oe)
    );

    int checks = 0;
    int fails  = 0;
    int rv_cnt = 0;
    int rise_cnt = 0;
    int fall_cnt = 0;
    int m_base = 0;
    logic [W-1:0] m_word = '0;
    logic [W-1:0] cap = '0;

    always @(posedge clk) if (rx_valid) rv_cnt <= rv_cnt + 1;
    always @(posedge sck_o) begin
        rise_cnt <= rise_cnt + 1;
        cap <= {cap[W-2:0], mosi_o};
    end
    always @(negedge sck_o) fall_cnt <= fall_cnt + 1;

    always_comb begin
        int idx;
        idx = fall_cnt - m_base;
        miso_i = (idx >= 0 && idx < W) ? m_word[W-1-idx] : 1'b0;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // one slave word, bench acting as the remote master
    task automatic slave_word(input logic [W-1:0] tx, input logic [W-1:0] mo,
                              input bit do_load, input logic [W-1:0] exp_tx);
        int rv0;
        logic [W-1:0] got;
        got = '0;
        if (do_load) begin
            tx_word = tx; tx_load = 1'b1; tick(1); tx_load = 1'b0;
        end
        tick(4);
        chk(hreq_oe && !hreq_o, "R2", "ready low after load", {hreq_oe, hreq_o}, 2'b10);
        rv0 = rv_cnt;
        ss_n = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            mosi_i = mo[i];
            tick(8);
            sck_i = 1'b1;
            got[i] = miso_o;
            tick(8);
            if (i == W - 1) chk(hreq_o, "R2", "ready high after first rise", hreq_o, 1);
            sck_i = 1'b0;
        end
        tick(8);
        ss_n = 1'b1;
        tick(2);
        chk(got == exp_tx && rx_word == mo && rv_cnt == rv0 + 1, "R1",
            "slave exchange", {got, rx_word}, {exp_tx, mo});
    endtask

    // one master word, bench acting as the remote slave
    task automatic master_word(input logic [W-1:0] tx, input logic [W-1:0] sl,
                               input bit hs, input string req);
        int r0, rv0, n;
        m_word = sl; m_base = fall_cnt; hreq_i = 1'b1;
        tx_word = tx; tx_load = 1'b1; tick(1); tx_load = 1'b0;
        r0 = rise_cnt; rv0 = rv_cnt;
        if (hs) begin
            tick(20);
            chk(rise_cnt == r0, "R5", "no start while hreq high", rise_cnt - r0, 0);
            hreq_i = 1'b0; tick(6); hreq_i = 1'b1;
        end
        n = 0;
        while (rv_cnt == rv0 && n < 400) begin tick(1); n++; end
        tick(2);
        chk(cap == tx && rx_word == sl && rise_cnt == r0 + W && !sck_o, req,
            "master exchange", {cap, rx_word}, {tx, sl});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int r0, rv0;
        tick(3);
        // R6 reset state (ss_n held low during reset)
        chk(!hreq_oe && !miso_oe && !bus_err && !sck_o && !rx_valid, "R6",
            "reset outputs", {hreq_oe, miso_oe, bus_err, sck_o, rx_valid}, 0);
        rst_n = 1'b1; ss_n = 1'b1;
        tick(4);
        chk(hreq_oe && hreq_o, "R6", "slave enabled idle", {hreq_oe, hreq_o}, 2'b11);
        cfg_hreq_en = 2'b00; tick(1);
        chk(!hreq_oe, "R6", "enable 00 releases pin", hreq_oe, 0);
        cfg_hreq_en = 2'b01; tick(1);

        // R3: slave select high, SCK ignored
        tx_word = 8'hA5; tx_load = 1'b1; tick(1); tx_load = 1'b0;
        rv0 = rv_cnt;
        for (int i = 0; i < W; i++) begin
            sck_i = 1'b1; tick(8); sck_i = 1'b0; tick(8);
        end
        chk(rv_cnt == rv0 && !hreq_o && !miso_oe, "R3", "edges ignored, miso released",
            {rv_cnt - rv0, hreq_o, miso_oe}, 0);
        // R9: second load while ready is ignored
        slave_word(8'h3C, 8'h96, 1'b1, 8'hA5);

        cfg_hreq_en = 2'b10;
        for (int v = 0; v < 256; v++)
            slave_word(W'(v), W'(v * 37 + 11), 1'b1, W'(v));

        // master mode
        cfg_master = 1'b1; cfg_hreq_en = 2'b11; tick(2);
        chk(!hreq_oe, "R6", "master releases hreq pin", hreq_oe, 0);
        for (int v = 0; v < 256; v++)
            master_word(W'(v), ~W'(v), 1'b1, "R4");

        cfg_hreq_en = 2'b00;
        master_word(8'h5A, 8'hC3, 1'b0, "R4");
        cfg_hreq_en = 2'b11;

        // R9: load during a master word is ignored
        m_word = 8'h81; m_base = fall_cnt;
        tx_word = 8'hE7; tx_load = 1'b1; tick(1); tx_load = 1'b0;
        hreq_i = 1'b0; tick(30);
        tx_word = 8'h18; tx_load = 1'b1; tick(1); tx_load = 1'b0;
        hreq_i = 1'b1; tick(80);
        chk(cap == 8'hE7 && rx_word == 8'h81, "R9", "mid-word load ignored", cap, 8'hE7);

        // R7 / R8: bus error and same-cycle clear
        ss_n = 1'b0; tick(4);
        chk(bus_err, "R7", "ss low in master sets error", bus_err, 1);
        err_clr = 1'b1; tick(1); err_clr = 1'b0; tick(1);
        chk(bus_err, "R7", "set wins over clear", bus_err, 1);
        ss_n = 1'b1; tick(6);
        chk(bus_err, "R7", "error sticky", bus_err, 1);
        m_word = 8'h42; m_base = fall_cnt;
        tx_word = 8'h99; tx_load = 1'b1; tick(1); tx_load = 1'b0;
        r0 = rise_cnt; rv0 = rv_cnt;
        hreq_i = 1'b0; tick(40);
        chk(rise_cnt == r0 && rv_cnt == rv0, "R8", "no start under error", rise_cnt - r0, 0);
        err_clr = 1'b1; tick(1); err_clr = 1'b0; tick(1);
        chk(!bus_err, "R7", "clear pulse", bus_err, 0);
        tick(10); hreq_i = 1'b1; tick(80);
        chk(cap == 8'h99 && rx_word == 8'h42 && rv_cnt == rv0 + 1, "R8",
            "word runs after clear", cap, 8'h99);

        report();
        $finish;
    end
endmodule